// File: doc/BRIEF.md
# Multi-Select Serial Slave Port

This block is the slave end of an eight-line link between a host controller and a logic device. The host owns the serial clock and the host-to-slave data line, and it drives four active-low strobes: a link reset, a write select, a read select and a fast-access select. The slave answers on one serial data line and on a ready line that drops while a command is in progress and rises again when it is done.

Every host line is brought into the fast system clock through a two-flop synchronizer. Edges of the serial clock are then found in the system clock domain, so that clock must run at least four times faster than the serial clock. Data moves most significant bit first. The slave samples on the rising serial edge and changes its output after the falling edge.

- A write shifts one word in and presents it on a parallel output.
- A read loads a word from internal logic and shifts it out.
- A fast access does both at once, for single quick exchanges such as one converter sample.
- If the host asserts two or more selects together, the block raises a protocol error flag and moves no data.

Top module: `strobe_serial_slave`

## Requirements
- R1: After system reset, and whenever the host link reset is low, `dev_sdo` is 0, `dev_done` is 1, `proto_err` is 0 and no word is delivered.
- R2: With only the write select low, the slave samples `host_sdo` on each rising `host_sclk` edge, MSB first. After WORD_W rising edges it pulses `wr_valid` for one system cycle, with the word on `wr_data` and `word_fast` = 0.
- R3: When the read or fast select goes low alone, the slave captures `rd_data` and pulses `rd_take` once. It drives the word's MSB on `dev_sdo` before the first rising edge and moves to the next bit after each falling edge.
- R4: With only the fast select low, the slave shifts out `rd_data` and shifts in a word at the same time. After WORD_W rising edges it pulses `wr_valid` with `word_fast` = 1.
- R5: `dev_done` is 0 from the moment a single select is taken until WORD_W rising edges have been seen, and is 1 from then on.
- R6: `dev_sdo` is 0 whenever `dev_done` is 1, and always outside a read or fast transfer.
- R7: If more than one select is low at the same time, `proto_err` goes to 1, `dev_done` stays 1 and no word moves. The flag stays set until the host link reset goes low.
- R8: Releasing the select before WORD_W bits have been transferred aborts the transfer. No word is delivered, `dev_done` returns to 1, and the next transfer starts again from bit 0.
- R9: Pulling the host link reset low during a transfer aborts it with no word delivered. It also clears `proto_err`.
- R10: Serial clock edges while no select is low have no effect: no word, `dev_done` stays 1, `dev_sdo` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | System reset, active low |
| host_sclk | input | 1 | Serial clock from the host, idles low |
| host_sdo | input | 1 | Serial data from the host, idles low |
| host_rst_n | input | 1 | Link reset from the host, active low |
| host_wr_n | input | 1 | Write select, active low |
| host_rd_n | input | 1 | Read select, active low |
| host_fast_n | input | 1 | Fast-access select, active low |
| dev_sdo | output | 1 | Serial data to the host, idles low |
| dev_done | output | 1 | Finished / ready, high when idle |
| proto_err | output | 1 | Sticky flag: more than one select was low at once |
| wr_data | output | WORD_W | Last received word |
| wr_valid | output | 1 | One-cycle strobe: `wr_data` is new |
| word_fast | output | 1 | The new word came from a fast access |
| rd_data | input | WORD_W | Word to return to the host |
| rd_take | output | 1 | One-cycle strobe: `rd_data` was captured |

## Verification
Write, read and fast transfers are each swept over all 256 word values. In the fast case the returned word differs from the received one, so a swap of the two shift paths shows up. Walking and alternating patterns inside that sweep catch bit-order and off-by-one counting faults, because any stuck, reversed or shifted bit changes the word. Separate sequences give the selects overlapping, the select dropped after three bits, the link reset asserted mid-read, and serial clocks with no select. These show that error, abort and idle all move no data, and that the bit counter restarts after an abort.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_FAST,
        ST_DONE,
        ST_ERR
    } sss_state_e;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL[i]}};
            else        stage_q <= {stage_q[0], d[i]};
        end
        assign q[i] = stage_q[1];
    end
endmodule

// File: rtl/sss_edge.sv
module sss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic rise,
    output logic fall
);
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s;
    end
    assign rise = s & ~prev_q;
    assign fall = ~s & prev_q;
endmodule

// File: rtl/strobe_serial_slave.sv
module strobe_serial_slave #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_sdo,
    input  logic              host_rst_n,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              host_fast_n,
    output logic              dev_sdo,
    output logic              dev_done,
    output logic              proto_err,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    output logic              word_fast,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_take
);
    import sss_pkg::*;

    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int LINES  = 6;
    // line order: fast_n, rd_n, wr_n, rst_n, sdo, sclk
    localparam logic [LINES-1:0] LINE_IDLE = 6'b111100;

    typedef struct packed {
        sss_state_e        state;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              fast;
        logic              take;
    } sss_regs_t;

    logic [LINES-1:0] raw_lines, syn_lines;
    logic             s_sclk, s_sdo, s_hrst_n, s_wr_n, s_rd_n, s_fast_n;
    logic             sclk_rise, sclk_fall;
    logic [2:0]       sel_act;
    int               sel_cnt;
    logic             own_sel;
    logic [WORD_W-1:0] rx_next;
    sss_regs_t        r_d, r_q;

    assign raw_lines = {host_fast_n, host_rd_n, host_wr_n, host_rst_n, host_sdo, host_sclk};

    sss_sync #(.N(LINES), .RST_VAL(LINE_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (syn_lines)
    );

    assign {s_fast_n, s_rd_n, s_wr_n, s_hrst_n, s_sdo, s_sclk} = syn_lines;

    sss_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .s     (s_sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    assign sel_act = {~s_fast_n, ~s_rd_n, ~s_wr_n};
    assign sel_cnt = $countones(sel_act);
    assign rx_next = {r_q.rx[WORD_W-2:0], s_sdo};

    always_comb begin
        case (r_q.state)
            ST_WRITE: own_sel = (sel_act == 3'b001);
            ST_READ:  own_sel = (sel_act == 3'b010);
            ST_FAST:  own_sel = (sel_act == 3'b100);
            default:  own_sel = 1'b0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.take  = 1'b0;
        if (!s_hrst_n) begin
            r_d.state = ST_IDLE;
            r_d.err   = 1'b0;
            r_d.cnt   = '0;
        end else begin
            case (r_q.state)
                ST_IDLE: begin
                    if (sel_cnt > 1) begin
                        r_d.state = ST_ERR;
                        r_d.err   = 1'b1;
                    end else if (sel_cnt == 1) begin
                        r_d.cnt = '0;
                        r_d.rx  = '0;
                        if (sel_act[0]) begin
                            r_d.state = ST_WRITE;
                        end else begin
                            r_d.tx    = rd_data;
                            r_d.take  = 1'b1;
                            r_d.state = sel_act[1] ? ST_READ : ST_FAST;
                        end
                    end
                end
                ST_WRITE, ST_READ, ST_FAST: begin
                    if (!own_sel) begin
                        r_d.state = (sel_cnt == 0) ? ST_IDLE : ST_ERR;
                        r_d.err   = r_q.err | (sel_cnt > 1);
                    end else if (sclk_rise) begin
                        r_d.rx  = rx_next;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(WORD_W - 1)) begin
                            r_d.state = ST_DONE;
                            if (r_q.state != ST_READ) begin
                                r_d.word  = rx_next;
                                r_d.valid = 1'b1;
                                r_d.fast  = (r_q.state == ST_FAST);
                            end
                        end
                    end else if (sclk_fall) begin
                        r_d.tx = {r_q.tx[WORD_W-2:0], 1'b0};
                    end
                end
                ST_DONE, ST_ERR: begin
                    if (sel_cnt == 0) r_d.state = ST_IDLE;
                    else if (sel_cnt > 1) r_d.err = 1'b1;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dev_sdo   = ((r_q.state == ST_READ) || (r_q.state == ST_FAST)) & r_q.tx[WORD_W-1];
    assign dev_done  = !((r_q.state == ST_WRITE) || (r_q.state == ST_READ) || (r_q.state == ST_FAST));
    assign proto_err = r_q.err;
    assign wr_data   = r_q.word;
    assign wr_valid  = r_q.valid;
    assign word_fast = r_q.fast;
    assign rd_take   = r_q.take;
endmodule

// File: rtl/sss_checker.sv
module sss_checker (
    input logic clk,
    input logic rst_n,
    input logic dev_sdo,
    input logic dev_done,
    input logic proto_err,
    input logic wr_valid,
    input logic rd_take
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R2
    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> !rd_take); // R3
    AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> !dev_done); // R5
    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> dev_done); // R5
    AST_SDO_LOW_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_done |-> !dev_sdo); // R6
    AST_ERR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && !$past(proto_err)) |-> dev_done); // R7
    AST_ERR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> !wr_valid); // R7
endmodule

bind strobe_serial_slave sss_checker u_sss_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_sdo   (dev_sdo),
    .dev_done  (dev_done),
    .proto_err (proto_err),
    .wr_valid  (wr_valid),
    .rd_take   (rd_take)
);

// File: tb/strobe_serial_slave_bench.sv
module strobe_serial_slave_bench;
    localparam int W    = 8;
    localparam int HALF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_sclk = 1'b0, host_sdo = 1'b0, host_rst_n = 1'b1;
    logic         host_wr_n = 1'b1, host_rd_n = 1'b1, host_fast_n = 1'b1;
    logic         dev_sdo, dev_done, proto_err, wr_valid, word_fast, rd_take;
    logic [W-1:0] wr_data, rd_data = '0;

    int checks = 0, errors = 0;
    int n_valid = 0, n_take = 0;
    logic [W-1:0] last_word = '0;
    logic         last_fast = 1'b0;

    always #5 clk = ~clk;

    strobe_serial_slave #(.WORD_W(W)) u_strobe_serial_slave (
        .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_sdo(host_sdo),
        .host_rst_n(host_rst_n), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
        .host_fast_n(host_fast_n), .dev_sdo(dev_sdo), .dev_done(dev_done),
        .proto_err(proto_err), .wr_data(wr_data), .wr_valid(wr_valid),
        .word_fast(word_fast), .rd_data(rd_data), .rd_take(rd_take)
    );

    always @(posedge clk) begin
        if (wr_valid) begin
            n_valid   <= n_valid + 1;
            last_word <= wr_data;
            last_fast <= word_fast;
        end
        if (rd_take) n_take <= n_take + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_bits(input logic [W-1:0] bits, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            host_sdo  = bits[i];
            host_sclk = 1'b1; waitn(HALF);
            host_sclk = 1'b0; waitn(HALF);
        end
        host_sdo = 1'b0;
    endtask

    // kind: 0 write, 1 read, 2 fast
    task automatic xfer(input int kind, input logic [W-1:0] wv, input logic [W-1:0] rv);
        int v0, t0;
        logic [W-1:0] got;
        v0 = n_valid; t0 = n_take;
        rd_data = rv;
        case (kind)
            0: host_wr_n = 1'b0;
            1: host_rd_n = 1'b0;
            default: host_fast_n = 1'b0;
        endcase
        waitn(HALF);
        check(dev_done == 1'b0, "R5 busy", dev_done, 0);
        if (kind != 0) check(n_take == t0 + 1, "R3 take", n_take - t0, 1);
        got = '0;
        for (int i = W - 1; i >= 0; i--) begin
            got[i]    = dev_sdo;
            host_sdo  = wv[i];
            host_sclk = 1'b1; waitn(HALF);
            host_sclk = 1'b0; waitn(HALF);
        end
        host_sdo = 1'b0;
        check(dev_done == 1'b1, "R5 done", dev_done, 1);
        check(dev_sdo == 1'b0, "R6 idle sdo", dev_sdo, 0);
        if (kind == 0) begin
            check(n_valid == v0 + 1 && last_word == wv && !last_fast, "R2 write word", last_word, wv);
        end else if (kind == 1) begin
            check(got == rv, "R3 read word", got, rv);
            check(n_valid == v0, "R3 no word on read", n_valid - v0, 0);
        end else begin
            check(got == rv, "R4 fast out", got, rv);
            check(n_valid == v0 + 1 && last_word == wv && last_fast, "R4 fast in", last_word, wv);
        end
        host_wr_n = 1'b1; host_rd_n = 1'b1; host_fast_n = 1'b1;
        waitn(HALF);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int v0;
        waitn(4);
        rst_n = 1'b1;
        waitn(4);
        check(dev_sdo == 0 && dev_done == 1 && proto_err == 0 && n_valid == 0, "R1 reset",
              {dev_sdo, dev_done, proto_err}, 3'b010);

        // R10: serial clocks with no select
        pulse_bits(8'hFF, W);
        check(n_valid == 0 && dev_done && !dev_sdo, "R10 idle clocks", n_valid, 0);

        for (int v = 0; v < 256; v++) xfer(0, W'(v), '0);
        for (int v = 0; v < 256; v++) xfer(1, '0, W'(v));
        for (int v = 0; v < 256; v++) xfer(2, W'(v), W'(v) ^ 8'h5A);

        // R7: overlapping selects
        v0 = n_valid;
        host_wr_n = 1'b0; host_rd_n = 1'b0;
        waitn(HALF);
        check(proto_err == 1 && dev_done == 1, "R7 error flag", {proto_err, dev_done}, 2'b11);
        pulse_bits(8'hFF, W);
        check(n_valid == v0 && !dev_sdo, "R7 no transfer", n_valid - v0, 0);
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        waitn(HALF);
        xfer(0, 8'hA5, '0);
        check(proto_err == 1, "R7 sticky", proto_err, 1);

        // R8: abort after three bits, then restart cleanly
        v0 = n_valid;
        host_wr_n = 1'b0; waitn(HALF);
        pulse_bits(8'h07, 3);
        host_wr_n = 1'b1; waitn(HALF);
        check(n_valid == v0 && dev_done, "R8 abort", n_valid - v0, 0);
        xfer(0, 8'h3C, '0);

        // R9: link reset during a read
        v0 = n_valid;
        host_rd_n = 1'b0; rd_data = 8'hFF; waitn(HALF);
        pulse_bits(8'h00, 2);
        host_rst_n = 1'b0; waitn(HALF);
        check(dev_done == 1 && dev_sdo == 0 && proto_err == 0, "R9 link reset",
              {dev_done, dev_sdo, proto_err}, 3'b100);
        check(proto_err == 0 && n_valid == v0, "R1 idle under link reset", proto_err, 0);
        host_rd_n = 1'b1; waitn(HALF);
        host_rst_n = 1'b1; waitn(HALF);
        xfer(2, 8'hC3, 8'h81);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule